// File: doc/BRIEF.md
# Prescaled General-Purpose Timer Channel

This block is one timer channel with three programmable parts: a control word, a reload value and a counter that software can read. The count rate comes either from the system clock through a power-of-two prescaler or from rising edges on an external event pin. The channel counts up or down over a 16-bit or 32-bit range.

The channel has four modes. It can count freely, count only while a synchronized gate pin sits at a chosen level, or act as the upper half of a pair and advance once per carry pulse from a lower partner timer. On reaching its terminal value it sets a sticky status flag. It then either reloads or stops. The flag drives an interrupt request when that request is enabled, and software clears it through the control word. A debug-halt input can freeze the channel when the control word asks for it.

Software writes with a single-cycle strobe and reads through a combinational mux. Address 0 is the control word, address 1 is the reload value, address 2 is the current count (read only) and address 3 is the status word, with the flag at bit 0.

Top module: `gp_timer`

## Requirements
- R1: After reset the count, the status flag, the irq output and the control word all read 0.
- R2: Control bit 0 is the enable. Writing it as 1 while it is 0 loads the count from the reload value, truncated to the selected width. While the enable is 0 the count holds.
- R3: Control bits 3:1 select the count rate when their value k is 0 to 6. The count then advances once every 2^k clock cycles, and the first advance comes 2^k cycles after the enabling write.
- R4: A clkSel value of 7 makes the count advance once per rising edge of extClk, after a two-flop synchronizer.
- R5: Control bits 5:4 choose the mode. Mode 1 counts only while the synchronized extGate is 0, and mode 2 counts only while it is 1. Mode 0 counts without gating.
- R6: In mode 3 the count advances once per clock cycle in which chainCarry is 1, and clkSel is ignored.
- R7: Control bit 6 set means count down, clear means count up. Bit 7 set means a 32-bit range, clear means 16-bit. The terminal value is all ones of that range when counting up and zero when counting down.
- R8: When the count reaches its terminal value, the status flag is set. On the next advance the count reloads if control bit 8 is set. If bit 8 is clear the count stays at the terminal value.
- R9: The status flag stays set until a control write with bit 10 set clears it, and bit 10 itself is not stored. irq equals the flag ANDed with control bit 9.
- R10: With control bit 11 set, the count and the prescaler freeze while dbgHalt is 1. With bit 11 clear, dbgHalt has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address |
| wrData | input | 32 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 32 | Read data, combinational |
| extClk | input | 1 | External event input |
| extGate | input | 1 | External gate level |
| chainCarry | input | 1 | Carry pulse from the lower chained timer |
| dbgHalt | input | 1 | CPU debug-halt indication |
| irq | output | 1 | Interrupt request |

## Verification
A table of vectors runs the counter under several combinations of rate, direction, width, reload, gate level and debug halt. Each combination gives a final count that only the correct combination of those settings can produce. Pairs of vectors differ in one setting to isolate its effect, for example:
- reload on against reload off
- 16-bit against 32-bit wrap
- gate high against gate low
- freeze on against freeze off

Directed tests then cover external events, chain carry pulses, holding on disable, and clearing and masking the interrupt.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int CTRL_BITS = 12;
  localparam int B_EN = 0;
  localparam int B_SEL = 1;
  localparam int B_MODE = 4;
  localparam int B_DOWN = 6;
  localparam int B_WIDE = 7;
  localparam int B_RLD = 8;
  localparam int B_IRQ = 9;
  localparam int B_CLR = 10;
  localparam int B_FRZ = 11;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_RLD = 2'd1;
  localparam logic [1:0] ADDR_CNT = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_GATE_LO = 2'd1,
    MODE_GATE_HI = 2'd2,
    MODE_CHAIN = 2'd3
  } gptMode_e;

  typedef struct packed {
    logic en;
    logic [2:0] clkSel;
    gptMode_e mode;
    logic down;
    logic wide;
    logic rldEn;
    logic irqEn;
    logic dbgFreeze;
  } gptCtrl_t;

  typedef struct packed {
    logic load;
    logic step;
    logic clrStat;
    logic rldWr;
  } gptStrobe_t;
endpackage

// File: rtl/gpt_ctrl.sv
module gpt_ctrl
  import gpt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_BITS = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [1:0] wrAddr,
  input  logic [CTRL_BITS-1:0] wrCtrl,
  input  logic extClk,
  input  logic extGate,
  input  logic chainCarry,
  input  logic dbgHalt,
  output gptCtrl_t ctrl,
  output gptStrobe_t strb
);
  logic [SYNC_STAGES:0] extPipe;
  logic [SYNC_STAGES-1:0] gatePipe;
  logic [PRE_BITS-1:0] pre, preMask;
  logic ctrlWr, extEdge, gateLvl, frozen, preTick, srcTick, modeOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extPipe <= '0;
      gatePipe <= '0;
    end else begin
      extPipe <= {extPipe[SYNC_STAGES-1:0], extClk};
      gatePipe <= {gatePipe[SYNC_STAGES-2:0], extGate};
    end
  end
  assign extEdge = extPipe[SYNC_STAGES-1] & ~extPipe[SYNC_STAGES];
  assign gateLvl = gatePipe[SYNC_STAGES-1];

  assign ctrlWr = wrEn && (wrAddr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrl <= '0;
    end else if (ctrlWr) begin
      ctrl.en <= wrCtrl[B_EN];
      ctrl.clkSel <= wrCtrl[B_SEL+:3];
      ctrl.mode <= gptMode_e'(wrCtrl[B_MODE+:2]);
      ctrl.down <= wrCtrl[B_DOWN];
      ctrl.wide <= wrCtrl[B_WIDE];
      ctrl.rldEn <= wrCtrl[B_RLD];
      ctrl.irqEn <= wrCtrl[B_IRQ];
      ctrl.dbgFreeze <= wrCtrl[B_FRZ];
    end
  end

  assign frozen = ctrl.dbgFreeze && dbgHalt;

  always_ff @(posedge clk) begin
    if (!rstN) pre <= '0;
    else if (strb.load) pre <= '0;
    else if (ctrl.en && !frozen) pre <= pre + 1'b1;
  end

  assign preMask = ~({PRE_BITS{1'b1}} << ctrl.clkSel);
  assign preTick = (pre & preMask) == preMask;
  assign srcTick = (ctrl.clkSel == 3'd7) ? extEdge : preTick;

  always_comb begin
    unique case (ctrl.mode)
      MODE_FREE: modeOk = srcTick;
      MODE_GATE_LO: modeOk = srcTick && !gateLvl;
      MODE_GATE_HI: modeOk = srcTick && gateLvl;
      default: modeOk = chainCarry;
    endcase
  end

  assign strb.load = ctrlWr && wrCtrl[B_EN] && !ctrl.en;
  assign strb.step = ctrl.en && !frozen && modeOk;
  assign strb.clrStat = ctrlWr && wrCtrl[B_CLR];
  assign strb.rldWr = wrEn && (wrAddr == ADDR_RLD);

  // R10
  freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.dbgFreeze && dbgHalt) |-> !strb.step);
  // R2
  step_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> ctrl.en);
endmodule

// File: rtl/gpt_datapath.sv
module gpt_datapath
  import gpt_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rstN,
  input  gptCtrl_t ctrl,
  input  gptStrobe_t strb,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] reload,
  output logic [WIDTH-1:0] count,
  output logic status
);
  localparam int HALF = WIDTH / 2;
  localparam logic [WIDTH-1:0] NARROW = {{(WIDTH-HALF){1'b0}}, {HALF{1'b1}}};

  logic [WIDTH-1:0] rangeMask, termVal, nextCnt;
  logic atTerm, setStat;

  assign rangeMask = ctrl.wide ? '1 : NARROW;
  assign termVal = ctrl.down ? '0 : rangeMask;
  assign atTerm = (count == termVal);
  assign nextCnt = (ctrl.down ? count - 1'b1 : count + 1'b1) & rangeMask;
  assign setStat = strb.step && !atTerm && (nextCnt == termVal);

  always_ff @(posedge clk) begin
    if (!rstN) reload <= '0;
    else if (strb.rldWr) reload <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strb.load) begin
      count <= reload & (wrData[B_WIDE] ? '1 : NARROW);
    end else if (strb.step) begin
      if (!atTerm) count <= nextCnt;
      else if (ctrl.rldEn) count <= reload & rangeMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) status <= 1'b0;
    else status <= setStat | (status & ~strb.clrStat);
  end

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.en && !strb.load) |=> $stable(count));
  // R8
  stop_at_term_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && atTerm && !ctrl.rldEn) |=> $stable(count));
  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status && !strb.clrStat) |=> status);
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import gpt_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_BITS = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [1:0] wrAddr,
  input  logic [31:0] wrData,
  input  logic [1:0] rdAddr,
  output logic [31:0] rdData,
  input  logic extClk,
  input  logic extGate,
  input  logic chainCarry,
  input  logic dbgHalt,
  output logic irq
);
  gptCtrl_t ctrl;
  gptStrobe_t strb;
  logic [WIDTH-1:0] reload, count;
  logic status;
  logic [CTRL_BITS-1:0] ctrlRd;

  gpt_ctrl #(.SYNC_STAGES(SYNC_STAGES), .PRE_BITS(PRE_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrCtrl(wrData[CTRL_BITS-1:0]), .extClk(extClk), .extGate(extGate),
    .chainCarry(chainCarry), .dbgHalt(dbgHalt), .ctrl(ctrl), .strb(strb)
  );

  gpt_datapath #(.WIDTH(WIDTH)) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .strb(strb),
    .wrData(wrData[WIDTH-1:0]), .reload(reload), .count(count), .status(status)
  );

  assign ctrlRd = {ctrl.dbgFreeze, 1'b0, ctrl.irqEn, ctrl.rldEn, ctrl.wide,
                   ctrl.down, ctrl.mode, ctrl.clkSel, ctrl.en};

  always_comb begin
    unique case (rdAddr)
      ADDR_CTRL: rdData = 32'(ctrlRd);
      ADDR_RLD: rdData = 32'(reload);
      ADDR_CNT: rdData = 32'(count);
      default: rdData = {31'd0, status};
    endcase
  end

  assign irq = status & ctrl.irqEn;
endmodule

// File: tb/tb_gp_timer.sv
module tb_gp_timer;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [1:0] wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0, rdData;
  logic extClk = 1'b0, extGate = 1'b0, chainCarry = 1'b0, dbgHalt = 1'b0, irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gp_timer dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .extClk(extClk),
    .extGate(extGate), .chainCarry(chainCarry), .dbgHalt(dbgHalt), .irq(irq));

  typedef struct packed {
    logic [11:0] ctrl;
    logic [31:0] rld;
    logic gate;
    logic halt;
    logic [15:0] cyc;
    logic [31:0] expCnt;
    logic expStat;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{12'h041, 32'd100, 1'b0, 1'b0, 16'd10, 32'd90, 1'b0},        // R7 down
    '{12'h001, 32'd5, 1'b0, 1'b0, 16'd7, 32'd12, 1'b0},           // R7 up
    '{12'h045, 32'd50, 1'b0, 1'b0, 16'd10, 32'd48, 1'b0},         // R3 div4
    '{12'h00D, 32'd0, 1'b0, 1'b0, 16'd130, 32'd2, 1'b0},          // R3 div64
    '{12'h101, 32'h0000FFFA, 1'b0, 1'b0, 16'd10, 32'h0000FFFE, 1'b1}, // R8 reload up
    '{12'h001, 32'h0000FFFA, 1'b0, 1'b0, 16'd10, 32'h0000FFFF, 1'b1}, // R8 stop up
    '{12'h081, 32'h0000FFFA, 1'b0, 1'b0, 16'd10, 32'h00010004, 1'b0}, // R7 wide
    '{12'h141, 32'd3, 1'b0, 1'b0, 16'd10, 32'd1, 1'b1},           // R8 reload down
    '{12'h041, 32'd3, 1'b0, 1'b0, 16'd10, 32'd0, 1'b1},           // R8 stop down
    '{12'h011, 32'd7, 1'b1, 1'b0, 16'd10, 32'd7, 1'b0},           // R5 gate-low blocked
    '{12'h011, 32'd7, 1'b0, 1'b0, 16'd10, 32'd17, 1'b0},          // R5 gate-low open
    '{12'h021, 32'd7, 1'b1, 1'b0, 16'd10, 32'd17, 1'b0},          // R5 gate-high open
    '{12'h801, 32'd7, 1'b0, 1'b1, 16'd10, 32'd7, 1'b0},           // R10 frozen
    '{12'h001, 32'd7, 1'b0, 1'b1, 16'd10, 32'd17, 1'b0},          // R10 halt ignored
    '{12'h041, 32'h00012345, 1'b0, 1'b0, 16'd5, 32'h00002340, 1'b0} // R2 load truncated
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rdAddr = a; #1; d = rdData;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finishRun();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rd(2'd2, v); chk("R1 count", v, 32'd0);
    rd(2'd3, v); chk("R1 status", v, 32'd0);
    rd(2'd0, v); chk("R1 ctrl", v, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      extGate = VECS[i].gate; dbgHalt = VECS[i].halt;
      wr(2'd0, 32'h0);
      wr(2'd0, 32'h400);
      wr(2'd1, VECS[i].rld);
      wr(2'd0, {20'd0, VECS[i].ctrl});
      repeat (int'(VECS[i].cyc)) @(negedge clk);
      rd(2'd2, v); chk($sformatf("R3/R5/R7/R8/R10 vec%0d count", i), v, VECS[i].expCnt);
      rd(2'd3, v); chk($sformatf("R8/R9 vec%0d status", i), v, {31'd0, VECS[i].expStat});
    end
    extGate = 1'b0; dbgHalt = 1'b0;

    // R2: disable holds the count
    wr(2'd0, 32'h0); wr(2'd0, 32'h400);
    wr(2'd1, 32'd100); wr(2'd0, 32'h041);
    repeat (5) @(negedge clk);
    wr(2'd0, 32'h040);
    repeat (10) @(negedge clk);
    rd(2'd2, v); chk("R2 hold when disabled", v, 32'd94);

    // R4: external events
    wr(2'd1, 32'd20); wr(2'd0, 32'h00F);
    for (int p = 0; p < 3; p++) begin
      extClk = 1'b1; repeat (2) @(negedge clk);
      extClk = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd(2'd2, v); chk("R4 external edges", v, 32'd23);

    // R6: chain carry
    wr(2'd0, 32'h0); wr(2'd1, 32'd10); wr(2'd0, 32'h031);
    repeat (4) @(negedge clk);
    rd(2'd2, v); chk("R6 no carry holds", v, 32'd10);
    for (int p = 0; p < 4; p++) begin
      chainCarry = 1'b1; @(negedge clk);
      chainCarry = 1'b0; @(negedge clk);
    end
    rd(2'd2, v); chk("R6 carry pulses", v, 32'd14);

    // R9: interrupt set, clear, mask
    wr(2'd0, 32'h0); wr(2'd0, 32'h400);
    wr(2'd1, 32'd3); wr(2'd0, 32'h241);
    repeat (10) @(negedge clk);
    chk("R9 irq raised", {31'd0, irq}, 32'd1);
    rd(2'd0, v); chk("R9 ctrl readback", v, 32'h241);
    wr(2'd0, 32'h641);
    rd(2'd3, v); chk("R9 status cleared", v, 32'd0);
    chk("R9 irq cleared", {31'd0, irq}, 32'd0);
    rd(2'd0, v); chk("R9 clear bit not stored", v, 32'h241);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'd2); wr(2'd0, 32'h041);
    repeat (10) @(negedge clk);
    rd(2'd3, v); chk("R9 status set unmasked", v, 32'd1);
    chk("R9 irq masked", {31'd0, irq}, 32'd0);

    finishRun();
  end
endmodule